// File: doc/BRIEF.md
# In-Order Completion Queue

A circular queue that records every instruction in program order from the moment it is dispatched until it retires. Dispatch claims up to three slots per cycle and receives one tag per slot. Execution units later report by tag that an entry has finished, and each report may carry an exception flag. The queue retires entries from its oldest end, up to three per cycle. An entry retires only when it has finished, carries no exception, and every entry ahead of it retires in the same cycle or has already retired.

Entries can be marked as branches when they are allocated. When a branch resolves as mispredicted, the queue pulls its allocation point back to the slot just after that branch. This discards every younger entry, and a flush output goes high in the resolve cycle. When an entry with an exception reaches the oldest position, retirement halts and the queue reports the entry's tag until an external clear arrives. Committing architectural state and servicing exceptions are handled outside the queue.

Top module: `cq_retire_queue`

## Requirements
- R1: After reset the queue is empty: `free_cnt` is 16, `retire_cnt` is 0, `exc_valid` and `flush` are 0, and the first offered tag is 0.
- R2: Tags are 5 bits: bits 3:0 give the slot and bit 4 is a wrap bit. The tags offered on `alloc_tags` are consecutive: slot i occupies bits 5i+4:5i and holds tail+i. A request of `alloc_cnt` entries is accepted, and `alloc_ok` is high, only when `alloc_cnt` is nonzero, does not exceed `free_cnt`, and no flush occurs in that cycle. A request that is not accepted allocates nothing.
- R3: `retire_cnt` gives the number of entries retiring in the current cycle (0 to 3), and `retire_tag` gives the tag of the oldest of them. Entries retire strictly from the oldest end.
- R4: A finished entry does not retire while any older entry is unfinished, even when it finished earlier than that entry.
- R5: When the oldest entry has finished with its exception flag set, retirement stops. From the next cycle on, `exc_valid` is 1 and `exc_tag` holds that entry's tag. Both hold, and `retire_cnt` stays 0, until `exc_clear` is pulsed. After the clear the entry is treated as finished without exception.
- R6: An entry with its exception flag set that is not the oldest blocks itself and all younger entries. Older finished entries still retire in the same cycle.
- R7: A branch resolve with `br_mispred` set, on a live entry that was allocated as a branch, raises `flush` in that same cycle. The next tail becomes the branch tag plus one, and the branch entry itself is kept and marked finished. Any allocation requested in the flush cycle is dropped.
- R8: A mispredict on a tag that is not live, or on a live entry that is not a branch, raises no flush and leaves the tail unchanged. A branch resolve without a mispredict marks the branch entry finished.
- R9: `free_cnt` equals 16 minus occupancy. It changes at the clock edge by the number retired minus the number allocated, and both can happen in the same cycle.
- R10: The wrap bit toggles when the slot index passes from 15 to 0. Age checks and the count of free entries remain correct across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_cnt | input | 2 | Number of entries requested this cycle (0 to 3) |
| alloc_br | input | 3 | Per-slot flag marking the new entry as a branch |
| alloc_ok | output | 1 | Request accepted this cycle |
| alloc_tags | output | 15 | Three offered tags, slot i in bits 5i+4:5i |
| fin_valid | input | 2 | Finish report valid, one bit per port |
| fin_tags | input | 10 | Finish tag per port, port f in bits 5f+4:5f |
| fin_exc | input | 2 | Exception flag per finish port |
| br_valid | input | 1 | Branch resolve valid |
| br_mispred | input | 1 | Resolved branch was mispredicted |
| br_tag | input | 5 | Tag of the resolved branch |
| flush | output | 1 | Younger entries are discarded this cycle |
| retire_cnt | output | 2 | Entries retiring this cycle |
| retire_tag | output | 5 | Tag of the oldest entry (first one retired) |
| exc_valid | output | 1 | Retirement halted on an exception |
| exc_tag | output | 5 | Tag of the entry that raised the exception |
| exc_clear | input | 1 | Releases an exception halt |
| free_cnt | output | 5 | Number of free entries |

## Verification
Two pairs of operations can fall in the same cycle. The first is retirement and allocation. The bench finishes the oldest entries while dispatch requests new slots in the same cycle, then checks that the free count moves by the difference between the two. The second is a mispredict and an allocation. The bench resolves a mispredicted branch while a three-slot request is pending, then checks that `flush` is high, that `alloc_ok` is low in that cycle, and that the next offered tag is the branch tag plus one.

// File: rtl/cq_retire_queue.sv
module cq_retire_queue #(
  parameter int DEPTH   = 16,
  parameter int ALLOC_W = 3,
  parameter int RET_W   = 3,
  parameter int FIN_W   = 2,
  localparam int IW = $clog2(DEPTH),
  localparam int TW = IW + 1,
  localparam int CW = $clog2(ALLOC_W + 1),
  localparam int RW = $clog2(RET_W + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CW-1:0]         alloc_cnt,
  input  logic [ALLOC_W-1:0]    alloc_br,
  output logic                  alloc_ok,
  output logic [ALLOC_W*TW-1:0] alloc_tags,
  input  logic [FIN_W-1:0]      fin_valid,
  input  logic [FIN_W*TW-1:0]   fin_tags,
  input  logic [FIN_W-1:0]      fin_exc,
  input  logic                  br_valid,
  input  logic                  br_mispred,
  input  logic [TW-1:0]         br_tag,
  output logic                  flush,
  output logic [RW-1:0]         retire_cnt,
  output logic [TW-1:0]         retire_tag,
  output logic                  exc_valid,
  output logic [TW-1:0]         exc_tag,
  input  logic                  exc_clear,
  output logic [TW-1:0]         free_cnt
);

  logic [TW-1:0]    head, tail, occ, br_off;
  logic [DEPTH-1:0] done_q, exc_q, br_q;
  logic             halt, br_live, head_exc;
  logic [IW-1:0]    a_idx [ALLOC_W];
  logic [IW-1:0]    f_idx [FIN_W];
  logic [FIN_W-1:0] f_live;
  logic [RET_W:0]   go;

  assign occ        = tail - head;
  assign free_cnt   = TW'(DEPTH) - occ;
  assign retire_tag = head;
  assign exc_valid  = halt;

  assign br_off  = br_tag - head;
  assign br_live = br_off < occ;
  assign flush   = br_valid && br_mispred && br_live && br_q[br_tag[IW-1:0]];

  assign alloc_ok = (alloc_cnt != '0) && (TW'(alloc_cnt) <= free_cnt) && !flush;

  for (genvar a = 0; a < ALLOC_W; a++) begin : g_alloc
    assign alloc_tags[a*TW +: TW] = tail + TW'(a);
    assign a_idx[a] = alloc_tags[a*TW +: IW];
  end

  for (genvar f = 0; f < FIN_W; f++) begin : g_fin
    logic [TW-1:0] off;
    assign off       = fin_tags[f*TW +: TW] - head;
    assign f_live[f] = off < occ;
    assign f_idx[f]  = fin_tags[f*TW +: IW];
  end

  assign go[0] = !halt;
  for (genvar r = 0; r < RET_W; r++) begin : g_ret
    logic [TW-1:0] t;
    assign t       = head + TW'(r);
    assign go[r+1] = go[r] && (TW'(r) < occ) && done_q[t[IW-1:0]] && !exc_q[t[IW-1:0]];
  end

  always_comb begin
    retire_cnt = '0;
    for (int r = 1; r <= RET_W; r++) retire_cnt += RW'(go[r]);
  end

  assign head_exc = !halt && (occ != '0) && done_q[head[IW-1:0]] && exc_q[head[IW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head    <= '0;
      tail    <= '0;
      done_q  <= '0;
      exc_q   <= '0;
      br_q    <= '0;
      halt    <= 1'b0;
      exc_tag <= '0;
    end else begin
      head <= head + TW'(retire_cnt);
      for (int f = 0; f < FIN_W; f++) begin
        if (fin_valid[f] && f_live[f]) begin
          done_q[f_idx[f]] <= 1'b1;
          exc_q[f_idx[f]]  <= fin_exc[f];
        end
      end
      if (br_valid && br_live) done_q[br_tag[IW-1:0]] <= 1'b1;
      if (halt && exc_clear) begin
        halt <= 1'b0;
        exc_q[head[IW-1:0]] <= 1'b0;
      end else if (head_exc) begin
        halt    <= 1'b1;
        exc_tag <= head;
      end
      if (flush) begin
        tail <= br_tag + TW'(1);
      end else if (alloc_ok) begin
        tail <= tail + TW'(alloc_cnt);
        for (int a = 0; a < ALLOC_W; a++) begin
          if (CW'(a) < alloc_cnt) begin
            done_q[a_idx[a]] <= 1'b0;
            exc_q[a_idx[a]]  <= 1'b0;
            br_q[a_idx[a]]   <= alloc_br[a];
          end
        end
      end
    end
  end

endmodule

module cq_retire_queue_chk #(
  parameter int DEPTH   = 16,
  parameter int ALLOC_W = 3,
  parameter int RET_W   = 3,
  localparam int IW = $clog2(DEPTH),
  localparam int TW = IW + 1,
  localparam int CW = $clog2(ALLOC_W + 1),
  localparam int RW = $clog2(RET_W + 1)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [CW-1:0]         alloc_cnt,
  input logic                  alloc_ok,
  input logic [ALLOC_W*TW-1:0] alloc_tags,
  input logic                  flush,
  input logic [TW-1:0]         br_tag,
  input logic [RW-1:0]         retire_cnt,
  input logic [TW-1:0]         retire_tag,
  input logic                  exc_valid,
  input logic [TW-1:0]         exc_tag,
  input logic                  exc_clear,
  input logic [TW-1:0]         free_cnt
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) free_cnt <= TW'(DEPTH)); // R9
  AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rst_n) !flush |=> free_cnt == $past(free_cnt) + TW'($past(retire_cnt)) - ($past(alloc_ok) ? TW'($past(alloc_cnt)) : TW'(0))); // R9
  AST_HALT_NO_RETIRE: assert property (@(posedge clk) disable iff (!rst_n) exc_valid |-> retire_cnt == '0); // R5
  AST_EXC_HOLD: assert property (@(posedge clk) disable iff (!rst_n) exc_valid && !exc_clear |=> exc_valid && $stable(exc_tag)); // R5
  AST_FLUSH_TAIL: assert property (@(posedge clk) disable iff (!rst_n) flush |=> alloc_tags[TW-1:0] == $past(br_tag) + TW'(1)); // R7
  AST_ALLOC_STEP: assert property (@(posedge clk) disable iff (!rst_n) alloc_ok |=> alloc_tags[TW-1:0] == $past(alloc_tags[TW-1:0]) + TW'($past(alloc_cnt))); // R2
  AST_RETIRE_ORDER: assert property (@(posedge clk) disable iff (!rst_n) retire_cnt != '0 |=> retire_tag == $past(retire_tag) + TW'($past(retire_cnt))); // R3

endmodule

bind cq_retire_queue cq_retire_queue_chk #(.DEPTH(DEPTH), .ALLOC_W(ALLOC_W), .RET_W(RET_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_cnt(alloc_cnt), .alloc_ok(alloc_ok), .alloc_tags(alloc_tags),
  .flush(flush), .br_tag(br_tag), .retire_cnt(retire_cnt), .retire_tag(retire_tag),
  .exc_valid(exc_valid), .exc_tag(exc_tag), .exc_clear(exc_clear), .free_cnt(free_cnt)
);

// File: tb/test_cq_retire_queue.sv
`timescale 1ns/1ps
module test_cq_retire_queue;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  alloc_cnt;
  logic [2:0]  alloc_br;
  logic        alloc_ok;
  logic [14:0] alloc_tags;
  logic [1:0]  fin_valid;
  logic [9:0]  fin_tags;
  logic [1:0]  fin_exc;
  logic        br_valid, br_mispred;
  logic [4:0]  br_tag;
  logic        flush;
  logic [1:0]  retire_cnt;
  logic [4:0]  retire_tag;
  logic        exc_valid;
  logic [4:0]  exc_tag;
  logic        exc_clear;
  logic [4:0]  free_cnt;

  int nchk = 0;
  int nerr = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  cq_retire_queue i_cq_retire_queue (.*);

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    alloc_cnt = 0; alloc_br = 0; fin_valid = 0; fin_tags = 0; fin_exc = 0;
    br_valid = 0; br_mispred = 0; br_tag = 0; exc_clear = 0;
  endtask

  task automatic fin(input int port, input logic [4:0] t, input logic e);
    fin_valid[port] = 1'b1;
    fin_tags[port*5 +: 5] = t;
    fin_exc[port] = e;
  endtask

  task automatic step();
    @(negedge clk);
    clr();
    #1;
  endtask

  task automatic t_reset();
    rst_n = 0; clr();
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    check("R1 free", free_cnt, 16);
    check("R1 retire", retire_cnt, 0);
    check("R1 exc", exc_valid, 0);
    check("R1 flush", flush, 0);
    check("R1 tag0", alloc_tags[4:0], 0);
  endtask

  task automatic t_order();
    alloc_cnt = 3; #1;
    check("R2 ok", alloc_ok, 1);
    check("R2 tag2", alloc_tags[14:10], 2);
    step();
    alloc_cnt = 3; #1;
    check("R2 tag0 next", alloc_tags[4:0], 3);
    step();
    check("R9 free after 6", free_cnt, 10);
    fin(0, 2, 0); fin(1, 1, 0);
    step();
    check("R4 no retire past unfinished", retire_cnt, 0);
    fin(0, 0, 0);
    step();
    check("R3 retire three", retire_cnt, 3);
    check("R3 oldest tag", retire_tag, 0);
    alloc_cnt = 2; fin(0, 3, 0); fin(1, 4, 0); #1;
    check("R9 alloc with retire ok", alloc_ok, 1);
    step();
    check("R9 free after retire+alloc", free_cnt, 11);
    check("R3 retire two", retire_cnt, 2);
    check("R3 tag3", retire_tag, 3);
    fin(0, 5, 0); fin(1, 6, 0);
    step();
    fin(0, 7, 0);
    step();
    step();
    check("R9 drained", free_cnt, 16);
  endtask

  task automatic t_exc();
    alloc_cnt = 2; step();
    fin(0, 8, 1); fin(1, 9, 0);
    step();
    check("R5 head exc blocks", retire_cnt, 0);
    step();
    check("R5 exc raised", exc_valid, 1);
    check("R5 exc tag", exc_tag, 8);
    step();
    check("R5 exc held", exc_valid, 1);
    check("R5 no retire halted", retire_cnt, 0);
    exc_clear = 1;
    step();
    check("R5 cleared", exc_valid, 0);
    check("R5 retire after clear", retire_cnt, 2);
    step();
    check("R5 drained", free_cnt, 16);
  endtask

  task automatic t_exc_mid();
    alloc_cnt = 3; step();
    fin(0, 10, 0); fin(1, 11, 1);
    step();
    check("R6 older retires", retire_cnt, 1);
    step();
    check("R6 blocked", retire_cnt, 0);
    step();
    check("R6 exc tag", exc_tag, 11);
    exc_clear = 1; fin(0, 12, 0);
    step();
    check("R6 retire after clear", retire_cnt, 2);
    step();
    check("R6 drained", free_cnt, 16);
  endtask

  task automatic t_flush();
    alloc_cnt = 3; alloc_br = 3'b010; step();
    alloc_cnt = 2; step();
    check("R9 occ five", free_cnt, 11);
    br_valid = 1; br_mispred = 1; br_tag = 14; alloc_cnt = 3; #1;
    check("R7 flush", flush, 1);
    check("R7 alloc dropped", alloc_ok, 0);
    step();
    check("R7 tail after branch", alloc_tags[4:0], 15);
    check("R7 free", free_cnt, 14);
    fin(0, 13, 0);
    step();
    check("R7 branch kept retires", retire_cnt, 2);
    step();
    check("R7 drained", free_cnt, 16);
  endtask

  task automatic t_ignore();
    alloc_cnt = 2; step();
    br_valid = 1; br_mispred = 1; br_tag = 15; #1;
    check("R8 non-branch no flush", flush, 0);
    step();
    check("R8 tail kept", alloc_tags[4:0], 17);
    check("R8 resolve finishes", retire_cnt, 1);
    br_valid = 1; br_mispred = 1; br_tag = 14; #1;
    check("R8 dead tag no flush", flush, 0);
    step();
    check("R8 tail kept dead", alloc_tags[4:0], 17);
    check("R8 free", free_cnt, 15);
    fin(0, 16, 0);
    step();
    step();
    check("R8 drained", free_cnt, 16);
  endtask

  task automatic t_wrap();
    for (int k = 0; k < 5; k++) begin
      alloc_cnt = 3; step();
    end
    check("R10 tag wraps", alloc_tags[4:0], 0);
    check("R10 free one", free_cnt, 1);
    alloc_cnt = 3; #1;
    check("R2 over request refused", alloc_ok, 0);
    step();
    check("R2 refused no change", free_cnt, 1);
    alloc_cnt = 1; #1;
    check("R2 fits", alloc_ok, 1);
    step();
    check("R9 full", free_cnt, 0);
    for (int k = 0; k < 8; k++) begin
      fin(0, 5'(17 + 2*k), 0); fin(1, 5'(18 + 2*k), 0);
      step();
    end
    repeat (4) step();
    check("R10 drained across wrap", free_cnt, 16);
    check("R10 head wrapped", retire_tag, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      nchk++; nerr++;
      $display("FAIL watchdog requirement=all actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_order();
    t_exc();
    t_exc_mid();
    t_flush();
    t_ignore();
    t_wrap();
    ended = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule